// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is one channel that sits beside a free-running 16-bit timer. A single 16-bit data register does three jobs, depending on a 4-bit mode field. It can latch the timer when an external pin changes. It can act as a target that the timer is compared against, with the output pin driven on a match. It can also hold the upper bits of a 10-bit PWM duty value. A sticky event flag records each capture and each compare match. Software clears that flag.

Software reaches the channel through a byte-wide write port and a combinational read port. The PWM period is produced outside the block. It arrives as a 10-bit period counter and a strobe that marks the start of each period. Timer prescaling is also done outside.

Top module: `ccp_channel`

## Requirements
- R1: Register map. Address 0 is control: bits 3:0 are the mode, bits 5:4 are the two duty LSBs, and bits 7:6 always read 0. Address 1 is the data low byte and address 2 the data high byte. Address 3 reads the flag in bit 0, and writing bit 0 = 1 clears it. After reset, control, data, flag and pin are all 0.
- R2: Mode 0000 drives the pin to 0 and clears the edge prescaler count. The flag keeps its value.
- R3: The pin input passes through two synchronizer flops. An edge is detected by comparing the second stage with a third flop. Mode 0101 captures on rising edges and mode 0100 on falling edges. The timer value is loaded at the third clock edge after the new pin level is first sampled, and the flag is set. A capture takes priority over a software write to the data register.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. When the count of edges seen is at or above the last step, the capture happens and the count restarts.
- R5: Mode 0010 toggles the pin on each compare match and sets the flag.
- R6: Mode 1000 sets the pin to 0 one clock after the mode is entered and sets it to 1 on a match. Mode 1001 does the opposite. A match in the entry cycle overrides the entry level. Both modes set the flag on a match.
- R7: Mode 1010 sets the flag on a match and leaves the pin unchanged.
- R8: The reserved codes 0001, 0011 and 1011 never capture, never set the flag, and hold the pin.
- R9: Any code 11xx selects PWM. On a period-start strobe, the duty value {data[7:0], control[5:4]} is latched and the pin goes high if that value is non-zero. Otherwise the pin goes low when the period counter equals the latched duty value. Outside PWM modes the pin comes from the compare logic.
- R10: The flag stays set until a clear write. A set event and a clear write in the same cycle leave the flag set.
- R11: A compare match is a cycle in which the timer equals the data register when it did not the cycle before. Holding the timer equal gives only one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_val | input | 16 | Free-running timer value |
| pin_in | input | 1 | Asynchronous capture input |
| period_start | input | 1 | PWM period start strobe |
| period_cnt | input | 10 | PWM period counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pin_out | output | 1 | Channel output pin |
| irq_flag | output | 1 | Sticky event flag |

## Verification
A prescaler count that has drifted shows up as a capture on the wrong rising edge. The data register and the flag then diverge in the very cycle after the third synchronizer edge. A wrong record of the previous mode or of the previous match moves the pin level one clock after a control write, or toggles the pin more than once while the timer is held equal. A corrupted duty latch only appears at the period counter match inside the next period, so a PWM fault can stay hidden for up to one full period. The reference model is compared against the pin, the flag and the rotating register read on every clock.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    parameter int TMR_W   = 16;
    parameter int DUTY_W  = 10;
    parameter int SYNC_N  = 2;
    parameter int PCNT_W  = 4;
    localparam int LSB_W  = DUTY_W - 8;

    localparam logic [3:0] M_OFF   = 4'b0000;
    localparam logic [3:0] M_TOG   = 4'b0010;
    localparam logic [3:0] M_CAPF  = 4'b0100;
    localparam logic [3:0] M_CAPR  = 4'b0101;
    localparam logic [3:0] M_CAP4  = 4'b0110;
    localparam logic [3:0] M_CAP16 = 4'b0111;
    localparam logic [3:0] M_SETHI = 4'b1000;
    localparam logic [3:0] M_SETLO = 4'b1001;
    localparam logic [3:0] M_FLAG  = 4'b1010;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_DLO  = 2'd1,
        ADR_DHI  = 2'd2,
        ADR_FLAG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [LSB_W-1:0] duty_lsb;
        logic [3:0]       mode;
    } ctrl_t;

    function automatic logic is_pwm(input logic [3:0] m);
        return m[3:2] == 2'b11;
    endfunction

    function automatic logic is_cmp(input logic [3:0] m);
        return (m == M_TOG) || (m == M_SETHI) || (m == M_SETLO) || (m == M_FLAG);
    endfunction

    function automatic logic is_rsv(input logic [3:0] m);
        return (m == 4'b0001) || (m == 4'b0011) || (m == 4'b1011);
    endfunction

    function automatic logic [PCNT_W-1:0] presc_last(input logic [3:0] m);
        return (m == M_CAP16) ? PCNT_W'(15) : PCNT_W'(3);
    endfunction

endpackage

// File: rtl/ccp_edge_cap.sv
module ccp_edge_cap
    import ccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic [3:0] mode,
    output logic       cap_stb
);

    logic [SYNC_N:0]       sh_q;
    logic [PCNT_W-1:0]     cnt_q;
    logic                  rise, fall, presc_mode, presc_hit;

    assign rise       = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    assign fall       = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
    assign presc_mode = (mode == M_CAP4) || (mode == M_CAP16);
    assign presc_hit  = presc_mode && rise && (cnt_q >= presc_last(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_N-1:0], pin_in};
            if (mode == M_OFF)
                cnt_q <= '0;
            else if (presc_mode && rise)
                cnt_q <= presc_hit ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        cap_stb = presc_hit;
        if ((mode == M_CAPF) && fall) cap_stb = 1'b1;
        if ((mode == M_CAPR) && rise) cap_stb = 1'b1;
    end

    // R2
    off_cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode) == M_OFF |-> cnt_q == '0);

endmodule

// File: rtl/ccp_cmp_unit.sv
module ccp_cmp_unit
    import ccp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       mode,
    input  logic [TMR_W-1:0] timer_val,
    input  logic [TMR_W-1:0] target,
    output logic             hit,
    output logic             out_q
);

    logic       eq, eq_q;
    logic [3:0] pmode_q;

    assign eq  = (timer_val == target);
    assign hit = eq && !eq_q && is_cmp(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q    <= 1'b0;
            pmode_q <= M_OFF;
            out_q   <= 1'b0;
        end else begin
            eq_q    <= eq;
            pmode_q <= mode;
            if (mode == M_OFF) begin
                out_q <= 1'b0;
            end else if (hit) begin
                case (mode)
                    M_TOG:   out_q <= ~out_q;
                    M_SETHI: out_q <= 1'b1;
                    M_SETLO: out_q <= 1'b0;
                    default: out_q <= out_q;
                endcase
            end else if (mode != pmode_q) begin
                if (mode == M_SETHI) out_q <= 1'b0;
                if (mode == M_SETLO) out_q <= 1'b1;
            end
        end
    end

    // R5
    tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == M_TOG) |=> out_q != $past(out_q));
    // R6
    set_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == M_SETHI) |=> out_q);
    // R6
    set_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == M_SETLO) |=> !out_q);
    // R7
    flag_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_FLAG && $past(mode) == M_FLAG) |=> $stable(out_q));

endmodule

// File: rtl/ccp_pwm_gen.sv
module ccp_pwm_gen
    import ccp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic [DUTY_W-1:0] pcnt,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              out_q
);

    logic [DUTY_W-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            duty_q <= '0;
            out_q  <= 1'b0;
        end else if (start) begin
            duty_q <= duty_in;
            out_q  <= (duty_in != '0);
        end else if (pcnt == duty_q) begin
            out_q  <= 1'b0;
        end
    end

    // R9
    pwm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (en && start && duty_in != '0) |=> out_q);
    // R9
    pwm_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !start && pcnt == duty_q) |=> !out_q);

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic              pin_in,
    input  logic              period_start,
    input  logic [DUTY_W-1:0] period_cnt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              pin_out,
    output logic              irq_flag
);

    ctrl_t             ctrl_q;
    logic [TMR_W-1:0]  data_q;
    logic              irq_q;
    logic              cap_stb, cmp_hit, cmp_out, pwm_out, set_evt, clr_wr;
    logic              wr_ctrl, wr_dlo, wr_dhi;
    logic [DUTY_W-1:0] duty_next;

    assign wr_ctrl   = wr_en && (reg_addr_e'(wr_addr) == ADR_CTRL);
    assign wr_dlo    = wr_en && (reg_addr_e'(wr_addr) == ADR_DLO);
    assign wr_dhi    = wr_en && (reg_addr_e'(wr_addr) == ADR_DHI);
    assign clr_wr    = wr_en && (reg_addr_e'(wr_addr) == ADR_FLAG) && wr_data[0];
    assign set_evt   = cap_stb | cmp_hit;
    assign duty_next = {data_q[7:0], ctrl_q.duty_lsb};

    ccp_edge_cap u_edge (
        .clk(clk), .rst(rst), .pin_in(pin_in), .mode(ctrl_q.mode), .cap_stb(cap_stb)
    );

    ccp_cmp_unit u_cmp (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .timer_val(timer_val),
        .target(data_q), .hit(cmp_hit), .out_q(cmp_out)
    );

    ccp_pwm_gen u_pwm (
        .clk(clk), .rst(rst), .en(is_pwm(ctrl_q.mode)), .start(period_start),
        .pcnt(period_cnt), .duty_in(duty_next), .out_q(pwm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.duty_lsb <= wr_data[5:4];
                ctrl_q.mode     <= wr_data[3:0];
            end
            if (cap_stb) begin
                data_q <= timer_val;
            end else begin
                if (wr_dlo) data_q[7:0]       <= wr_data;
                if (wr_dhi) data_q[TMR_W-1:8] <= wr_data;
            end
            if (set_evt)     irq_q <= 1'b1;
            else if (clr_wr) irq_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADR_CTRL: rd_data = {2'b00, ctrl_q.duty_lsb, ctrl_q.mode};
            ADR_DLO:  rd_data = data_q[7:0];
            ADR_DHI:  rd_data = data_q[TMR_W-1:8];
            default:  rd_data = {7'b0, irq_q};
        endcase
    end

    assign pin_out  = is_pwm(ctrl_q.mode) ? pwm_out : cmp_out;
    assign irq_flag = irq_q;

    // R3
    cap_latch_chk: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> data_q == $past(timer_val));
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_wr) |=> irq_q);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> irq_q);
    // R8
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_rsv(ctrl_q.mode) |-> !set_evt);
    // R2
    off_pin_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q.mode) == M_OFF |-> !pin_out);

endmodule

// File: tb/sim_ccp_channel.sv
`timescale 1ns/1ps
module sim_ccp_channel;

    localparam int PER = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr = '0;
    logic        pin = 1'b0;
    logic        ps = 1'b0;
    logic [9:0]  pcnt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        pin_out, irq;

    int nchk = 0, nfail = 0, cyc = 0, wdog = 0;
    bit run_t = 0, run_p = 0, hold_rd = 0, done = 0;

    always #5 clk = ~clk;

    ccp_channel u0 (
        .clk(clk), .rst(rst), .timer_val(tmr), .pin_in(pin), .period_start(ps),
        .period_cnt(pcnt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_out(pin_out), .irq_flag(irq)
    );

    // behavioural reference model
    int m_mode, m_lsb, m_data, m_flag, m_cmp, m_pwm, m_duty, m_cnt, m_peq, m_pmode;
    bit syncq[$];

    function automatic int m_pin();
        return (m_mode >= 12) ? m_pwm : m_cmp;
    endfunction

    function automatic int m_rd(input int a);
        case (a)
            0: return m_lsb * 16 + m_mode;
            1: return m_data % 256;
            2: return m_data / 256;
            default: return m_flag;
        endcase
    endfunction

    function automatic string tag_of(input int m);
        if (m == 0) return "R2";
        if (m == 4 || m == 5) return "R3";
        if (m == 6 || m == 7) return "R4";
        if (m == 2) return "R5";
        if (m == 8 || m == 9) return "R6";
        if (m == 10) return "R7";
        if (m >= 12) return "R9";
        return "R8";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_lsb = 0; m_data = 0; m_flag = 0; m_cmp = 0; m_pwm = 0;
            m_duty = 0; m_cnt = 0; m_peq = 0; m_pmode = 0;
            syncq = '{0, 0, 0};
        end else begin
            int mode, cap, hit, eq, lim;
            bit rise, fall;
            mode = m_mode;
            rise = syncq[1] && !syncq[0];
            fall = !syncq[1] && syncq[0];
            cap = 0;
            if (mode == 0) m_cnt = 0;
            else if ((mode == 6 || mode == 7) && rise) begin
                lim = (mode == 6) ? 4 : 16;
                if (m_cnt >= lim - 1) begin cap = 1; m_cnt = 0; end
                else m_cnt++;
            end
            if (mode == 4 && fall) cap = 1;
            if (mode == 5 && rise) cap = 1;
            eq  = (int'(tmr) == m_data);
            hit = (eq && !m_peq && (mode == 2 || mode == 8 || mode == 9 || mode == 10)) ? 1 : 0;
            if (mode == 0) m_cmp = 0;
            else begin
                if (mode != m_pmode && mode == 8) m_cmp = 0;
                if (mode != m_pmode && mode == 9) m_cmp = 1;
                if (hit && mode == 2) m_cmp = 1 - m_cmp;
                if (hit && mode == 8) m_cmp = 1;
                if (hit && mode == 9) m_cmp = 0;
            end
            if (mode < 12) begin m_pwm = 0; m_duty = 0; end
            else if (ps) begin m_duty = (m_data % 256) * 4 + m_lsb; m_pwm = (m_duty != 0); end
            else if (int'(pcnt) == m_duty) m_pwm = 0;
            if (wr_en && wr_addr == 3 && wr_data[0]) m_flag = 0;
            if (cap || hit) m_flag = 1;
            if (wr_en && wr_addr == 0) begin m_mode = wr_data[3:0]; m_lsb = wr_data[5:4]; end
            if (wr_en && wr_addr == 1) m_data = (m_data / 256) * 256 + wr_data;
            if (wr_en && wr_addr == 2) m_data = wr_data * 256 + m_data % 256;
            if (cap) m_data = tmr;
            m_peq = eq; m_pmode = mode;
            void'(syncq.pop_front());
            syncq.push_back(pin);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check(pin_out === 1'(m_pin()), tag_of(m_mode), pin_out, m_pin());
            check(irq === 1'(m_flag), "R10", irq, m_flag);
            check(rd_data === 8'(m_rd(rd_addr)), (rd_addr == 0) ? "R1" : tag_of(m_mode),
                  rd_data, m_rd(rd_addr));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        wdog++;
        if (wdog > 150000 && !done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic step();
        @(negedge clk);
        cyc++;
        if (run_t) tmr = tmr + 1'b1;
        if (run_p) begin
            pcnt = (pcnt == PER - 1) ? '0 : pcnt + 1'b1;
            ps = (pcnt == 0);
        end else ps = 1'b0;
        if (!hold_rd) rd_addr = 2'(cyc);
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        hold_rd = 1; rd_addr = a; #1; v = rd_data; hold_rd = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin = 1'b1; idle(5);
            pin = 1'b0; idle(5);
        end
    endtask

    initial begin
        logic [7:0] v;
        logic       p0;
        int         hi;
        idle(3);
        rst = 1'b0;
        step();
        // R1 reset state
        check(pin_out === 1'b0 && irq === 1'b0, "R1", {pin_out, irq}, 0);
        rd_reg(2'd0, v); check(v === 8'h00, "R1", v, 0);
        rd_reg(2'd2, v); check(v === 8'h00, "R1", v, 0);
        wr(2'd0, 8'hFF); step();
        rd_reg(2'd0, v); check(v === 8'h3F, "R1", v, 8'h3F);
        wr(2'd0, 8'h00); idle(2);

        // R3 rising capture with timer frozen
        run_t = 0; tmr = 16'h4321;
        wr(2'd0, 8'h05); idle(2);
        pin = 1'b1; step(); step(); tmr = 16'h5555; step(); tmr = 16'h0BAD; idle(3);
        rd_reg(2'd1, v); check(v === 8'h55, "R3", v, 8'h55);
        rd_reg(2'd2, v); check(v === 8'h55, "R3", v, 8'h55);
        check(irq === 1'b1, "R3", irq, 1);
        pin = 1'b0; idle(5);
        run_t = 1;
        pulses(3);
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h04); pulses(3);

        // R4 prescale by 4
        wr(2'd0, 8'h06); wr(2'd3, 8'h01);
        pulses(3);
        check(irq === 1'b0, "R4", irq, 0);
        pulses(1);
        check(irq === 1'b1, "R4", irq, 1);
        // R2 disable mid-count then resume
        wr(2'd3, 8'h01); pulses(2);
        wr(2'd0, 8'h00); step();
        check(pin_out === 1'b0, "R2", pin_out, 0);
        wr(2'd0, 8'h06); pulses(3);
        check(irq === 1'b0, "R2", irq, 0);
        wr(2'd0, 8'h07); pulses(18);

        // R5 / R11 toggle with timer held equal
        run_t = 0; tmr = 16'h1000;
        wr(2'd1, 8'h34); wr(2'd2, 8'h12); wr(2'd0, 8'h02); wr(2'd3, 8'h01); idle(2);
        p0 = pin_out;
        tmr = 16'h1234; idle(5);
        check(pin_out === ~p0, "R11", pin_out, ~p0);
        tmr = 16'h1235; step(); tmr = 16'h1234; idle(2);
        check(pin_out === p0, "R5", pin_out, p0);
        check(irq === 1'b1, "R5", irq, 1);

        // R10 set wins over clear
        tmr = 16'h1000; wr(2'd3, 8'h01); step();
        check(irq === 1'b0, "R10", irq, 0);
        tmr = 16'h1234; wr(2'd3, 8'h01);
        check(irq === 1'b1, "R10", irq, 1);
        tmr = 16'h1000; idle(3);
        check(irq === 1'b1, "R10", irq, 1);

        // R6 set-high / set-low
        wr(2'd0, 8'h08); step();
        check(pin_out === 1'b0, "R6", pin_out, 0);
        tmr = 16'h1234; step();
        check(pin_out === 1'b1, "R6", pin_out, 1);
        tmr = 16'h1000; wr(2'd0, 8'h09); step();
        check(pin_out === 1'b1, "R6", pin_out, 1);
        tmr = 16'h1234; step();
        check(pin_out === 1'b0, "R6", pin_out, 0);

        // R7 flag only
        tmr = 16'h1000; wr(2'd0, 8'h0A); wr(2'd3, 8'h01); step();
        p0 = pin_out;
        tmr = 16'h1234; idle(2);
        check(pin_out === p0, "R7", pin_out, p0);
        check(irq === 1'b1, "R7", irq, 1);

        // R8 reserved codes
        wr(2'd3, 8'h01);
        for (int k = 0; k < 3; k++) begin
            tmr = 16'h1000;
            wr(2'd0, (k == 0) ? 8'h01 : (k == 1) ? 8'h03 : 8'h0B);
            p0 = pin_out;
            tmr = 16'h1234; pulses(2);
            check(irq === 1'b0, "R8", irq, 0);
            check(pin_out === p0, "R8", pin_out, p0);
        end

        // R9 PWM, duty 22 of period 40
        run_t = 1; run_p = 1;
        wr(2'd1, 8'h05); wr(2'd0, 8'h2C);
        idle(2 * PER);
        hi = 0;
        for (int i = 0; i < 2 * PER; i++) begin step(); hi += pin_out; end
        check(hi == 44, "R9", hi, 44);
        wr(2'd1, 8'h00); wr(2'd0, 8'h0D);
        idle(2 * PER);
        hi = 0;
        for (int i = 0; i < 2 * PER; i++) begin step(); hi += pin_out; end
        check(hi == 0, "R9", hi, 0);
        wr(2'd1, 8'h20); wr(2'd0, 8'h1F);
        idle(3 * PER);
        wr(2'd0, 8'h00); idle(4);
        check(pin_out === 1'b0, "R2", pin_out, 0);

        finish_run();
    end

endmodule